// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences transfers for one DMA channel. An I/O device raises a request; the channel grants it with an acknowledge and then performs one transfer per clock. Each transfer presents the current address, pulses a pair of abstract strobes chosen by the transfer type, and steps the current address and count. When the count steps past zero to all ones, the service ends at terminal count. The current registers are then either reloaded from the base registers or the channel masks itself.

Software programs four items through a write port: the base address, the base count, a mode word, and a mask-clear command. The mode word picks one of three servicing disciplines. Block mode runs to terminal count once granted. Demand mode pauses whenever the request drops and resumes from the stored intermediate values. Cascade mode only grants the bus to an external master and stays off the address and strobe lines.

The state machine has three states. ST_IDLE moves to ST_XFER when a request is seen, the mask is clear and the mode is not cascade; it moves to ST_CASC when the request arrives in cascade mode. ST_XFER returns to ST_IDLE on the terminal-count transfer, or after a demand-mode cycle in which the request is low. ST_CASC returns to ST_IDLE when the request drops.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, dack, bus_en, tc and all four strobes are 0, addr_o and cnt_o are 0, and the channel is unmasked.
- R2: Config writes use cfg_sel 0 for base address, 1 for base count, 2 for the mode word and 3 for mask clear. A base write also loads the matching current register, but only while dack is 0. A base write during a service leaves cnt_o and the running address unchanged.
- R3: Each transfer cycle (bus_en high) shows the current address on addr_o. On the following edge the address steps by one, upward when mode bit 5 is 0 and downward when it is 1, wrapping modulo 2^16, and the count decrements by one.
- R4: tc is high in exactly the transfer cycle in which cnt_o is 0, so a count of N gives N+1 transfers. dack is 0 in the cycle after tc.
- R5: Block mode (mode bits [1:0] = 0, or 3) runs from the grant to terminal count regardless of dreq.
- R6: In demand mode (mode bits [1:0] = 1), a transfer cycle in which dreq is low is the last one of that service. Current address and count keep their values while idle, and the next grant resumes from them.
- R7: With auto-initialize set (mode bit 4 = 1), the edge after the terminal-count transfer reloads the current address and count from the base registers.
- R8: With auto-initialize clear, terminal count sets the mask and cnt_o reads 16'hFFFF. While masked, dreq yields no dack until a write with cfg_sel 3.
- R9: In cascade mode (mode bits [1:0] = 2), dack follows dreq with one cycle of latency. bus_en, all strobes, tc and addr_o stay 0, and cnt_o does not change.
- R10: Transfer type is mode bits [3:2]. Value 1 (write) drives io_rd and mem_wr; value 2 (read) drives mem_rd and io_wr; values 0 and 3 (verify) drive no strobe but still step address and count.
- R11: dack rises one cycle after dreq is sampled high with the channel idle and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 0 base addr, 1 base count, 2 mode, 3 mask clear |
| cfg_wdata | input | 16 | Config write data |
| dreq | input | 1 | Request from the device or cascaded master |
| dack | output | 1 | Grant to the device or master |
| bus_en | output | 1 | Channel drives the bus this cycle |
| addr_o | output | 16 | Transfer address, 0 when not driving |
| cnt_o | output | 16 | Current transfer count |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal-count transfer cycle |

## Verification
In demand mode, terminal count and the loss of the request can land in the same transfer cycle. The bench provokes this by lowering dreq during the final transfer of a demand service. It then expects tc in that cycle, dack low on the next one, the count reading 16'hFFFF with the mask set, and no grant when dreq is raised again. Without that mask, the request loss would look like an ordinary resumable pause. A base-count write during a cascade grant is a second collision between register loading and an active service; it must leave cnt_o unchanged.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
    typedef enum logic [1:0] {
        MD_BLOCK   = 2'd0,
        MD_DEMAND  = 2'd1,
        MD_CASCADE = 2'd2,
        MD_BLOCK2  = 2'd3
    } svc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CASC = 2'd2
    } seq_state_e;

    localparam logic [1:0] SEL_BADDR  = 2'd0;
    localparam logic [1:0] SEL_BCNT   = 2'd1;
    localparam logic [1:0] SEL_MODE   = 2'd2;
    localparam logic [1:0] SEL_UNMASK = 2'd3;

    localparam logic [1:0] XT_WRITE = 2'd1;
    localparam logic [1:0] XT_READ  = 2'd2;
endpackage

// File: rtl/dma_seq_ctl.sv
`timescale 1ns/1ps
module dma_seq_ctl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dreq,
    input  logic       mask,
    input  logic       cnt_zero,
    input  svc_mode_e  mode,
    output seq_state_e state,
    output logic       step,
    output logic       last
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dreq && !mask)
                    state_d = (mode == MD_CASCADE) ? ST_CASC : ST_XFER;
            end
            ST_XFER: begin
                if (cnt_zero)
                    state_d = ST_IDLE;
                else if (mode == MD_DEMAND && !dreq)
                    state_d = ST_IDLE;
            end
            ST_CASC: begin
                if (!dreq) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state = state_q;
        step  = (state_q == ST_XFER);
        last  = (state_q == ST_XFER) && cnt_zero;
    end

    p_block_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && mode != MD_DEMAND && !cnt_zero) |=> state_q == ST_XFER)
        else $error("block service left early");
    p_demand_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && mode == MD_DEMAND && !dreq) |=> state_q == ST_IDLE)
        else $error("demand service did not pause");
    p_casc_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CASC && !dreq) |=> state_q == ST_IDLE)
        else $error("cascade grant held after request drop");
    p_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && dreq && !mask) |=> state_q != ST_IDLE)
        else $error("request not granted");
endmodule

// File: rtl/dma_seq_regs.sv
`timescale 1ns/1ps
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         idle,
    input  logic         step,
    input  logic         last,
    input  logic         autoinit,
    input  logic         dec,
    output logic [W-1:0] cur_addr,
    output logic [W-1:0] cur_cnt,
    output logic         cnt_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
    logic [W-1:0] addr_next;
    logic         ld_addr, ld_cnt;

    assign ld_addr   = wr_en && wr_sel == SEL_BADDR;
    assign ld_cnt    = wr_en && wr_sel == SEL_BCNT;
    assign addr_next = dec ? cur_addr_q - ONE : cur_addr_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
        end else begin
            if (ld_addr) base_addr_q <= wr_data;
            if (ld_cnt)  base_cnt_q  <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            cur_cnt_q  <= '0;
        end else if (last && autoinit) begin
            cur_addr_q <= base_addr_q;
            cur_cnt_q  <= base_cnt_q;
        end else if (step) begin
            cur_addr_q <= addr_next;
            cur_cnt_q  <= cur_cnt_q - ONE;
        end else if (idle) begin
            if (ld_addr) cur_addr_q <= wr_data;
            if (ld_cnt)  cur_cnt_q  <= wr_data;
        end
    end

    assign cur_addr = cur_addr_q;
    assign cur_cnt  = cur_cnt_q;
    assign cnt_zero = (cur_cnt_q == '0);

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_zero) |=> cur_cnt_q == $past(cur_cnt_q) - ONE)
        else $error("count did not decrement");
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !autoinit) |=> cur_cnt_q == '1)
        else $error("count did not wrap at terminal count");
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last && autoinit && !ld_cnt) |=> cur_cnt_q == base_cnt_q)
        else $error("autoinit reload missing");
endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic         dreq,
    output logic         dack,
    output logic         bus_en,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] cnt_o,
    output logic         io_rd,
    output logic         io_wr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         tc
);
    localparam int MODE_W = 6;

    logic [MODE_W-1:0] mode_q;
    logic              mask_q;
    seq_state_e        state;
    logic              step, last, cnt_zero;
    logic [W-1:0]      cur_addr, cur_cnt;
    svc_mode_e         svc_mode;
    logic [1:0]        xtype;
    logic              autoinit, dec;

    assign svc_mode = svc_mode_e'(mode_q[1:0]);
    assign xtype    = mode_q[3:2];
    assign autoinit = mode_q[4];
    assign dec      = mode_q[5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel == SEL_MODE) mode_q <= cfg_wdata[MODE_W-1:0];
            if (last && !autoinit)                   mask_q <= 1'b1;
            else if (cfg_we && cfg_sel == SEL_UNMASK) mask_q <= 1'b0;
        end
    end

    dma_seq_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .mask     (mask_q),
        .cnt_zero (cnt_zero),
        .mode     (svc_mode),
        .state    (state),
        .step     (step),
        .last     (last)
    );

    dma_seq_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .idle     (state == ST_IDLE),
        .step     (step),
        .last     (last),
        .autoinit (autoinit),
        .dec      (dec),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .cnt_zero (cnt_zero)
    );

    always_comb begin
        dack   = 1'b0;
        bus_en = 1'b0;
        io_rd  = 1'b0;
        io_wr  = 1'b0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CASC: dack = 1'b1;
            ST_XFER: begin
                dack   = 1'b1;
                bus_en = 1'b1;
                if (xtype == XT_WRITE) begin
                    io_rd  = 1'b1;
                    mem_wr = 1'b1;
                end else if (xtype == XT_READ) begin
                    mem_rd = 1'b1;
                    io_wr  = 1'b1;
                end
            end
            default: ;
        endcase
        addr_o = bus_en ? cur_addr : '0;
        cnt_o  = cur_cnt;
        tc     = last;
    end

    p_tc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (bus_en && cnt_o == '0))
        else $error("tc outside final transfer");
    p_tc_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !dack)
        else $error("dack held after tc");
    p_strobe_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr) && !(mem_rd && mem_wr) &&
        ($countones({io_rd, io_wr, mem_rd, mem_wr}) != 1))
        else $error("bad strobe combination");
    p_casc_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !bus_en) |=> $stable(cnt_o))
        else $error("cascade grant changed count");
    p_mask_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack && mask_q) |=> !dack)
        else $error("masked channel granted");
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack && !(cfg_we && cfg_sel == SEL_BCNT)) |=> $stable(cnt_o))
        else $error("idle count changed");
endmodule

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dreq = 1'b0;
    logic        dack, bus_en, io_rd, io_wr, mem_rd, mem_wr, tc;
    logic [15:0] addr_o, cnt_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dma_chan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .bus_en(bus_en),
        .addr_o(addr_o), .cnt_o(cnt_o), .io_rd(io_rd), .io_wr(io_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] mword(input int md, input int ty, input bit ai, input bit dc);
        return {10'd0, dc, ai, 2'(ty), 2'(md)};
    endfunction

    function automatic logic [3:0] exp_strb(input int ty);
        // order {io_rd, io_wr, mem_rd, mem_wr}
        if (ty == 1) return 4'b1001;
        if (ty == 2) return 4'b0110;
        return 4'b0000;
    endfunction

    task automatic run_block(input int ty, input bit dc, input bit ai, input int n);
        logic [15:0] a0;
        logic [15:0] ea;
        a0 = dc ? 16'h0001 : 16'hFFFE;
        wr(2'd0, a0); wr(2'd1, 16'(n)); wr(2'd2, mword(0, ty, ai, dc)); wr(2'd3, 16'd0);
        dreq = 1'b1;
        tick();
        dreq = 1'b0;
        chk(dack === 1'b1, "R11 grant", 32'(dack), 1);
        for (int i = 0; i <= n; i++) begin
            ea = dc ? a0 - 16'(i) : a0 + 16'(i);
            chk(bus_en === 1'b1 && dack === 1'b1, "R5 block runs", 32'({dack, bus_en}), 3);
            chk(addr_o === ea, "R3 address step", 32'(addr_o), 32'(ea));
            chk(tc === (i == n), "R4 tc timing", 32'(tc), 32'(i == n));
            chk({io_rd, io_wr, mem_rd, mem_wr} === exp_strb(ty), "R10 strobes",
                32'({io_rd, io_wr, mem_rd, mem_wr}), 32'(exp_strb(ty)));
            tick();
        end
        chk(dack === 1'b0, "R4 dack drop", 32'(dack), 0);
        if (ai) begin
            chk(cnt_o === 16'(n), "R7 count reload", 32'(cnt_o), 32'(n));
            dreq = 1'b1;
            tick();
            dreq = 1'b0;
            chk(addr_o === a0, "R7 address reload", 32'(addr_o), 32'(a0));
            for (int i = 0; i <= n; i++) tick();
            chk(dack === 1'b0, "R7 second service ends", 32'(dack), 0);
        end else begin
            chk(cnt_o === 16'hFFFF, "R8 count wrap", 32'(cnt_o), 32'hFFFF);
            dreq = 1'b1;
            tick(); tick();
            chk(dack === 1'b0, "R8 masked", 32'(dack), 0);
            dreq = 1'b0;
        end
    endtask

    initial begin
        #1;
        tick(); tick();
        rst_n = 1'b1;
        chk({dack, bus_en, tc, io_rd, io_wr, mem_rd, mem_wr} === 7'b0, "R1 reset outputs",
            32'({dack, bus_en, tc, io_rd, io_wr, mem_rd, mem_wr}), 0);
        chk(addr_o === 16'd0 && cnt_o === 16'd0, "R1 reset regs", 32'({addr_o, cnt_o}), 0);
        dreq = 1'b1;
        tick();
        chk(dack === 1'b1, "R1 unmasked after reset", 32'(dack), 1);
        dreq = 1'b0;
        tick();

        // block sweep over type, direction, autoinit, count
        for (int ty = 0; ty < 3; ty++)
            for (int dc = 0; dc < 2; dc++)
                for (int ai = 0; ai < 2; ai++)
                    for (int k = 0; k < 3; k++)
                        run_block(ty, dc[0], ai[0], (k == 2) ? 3 : k);

        // R8 unmask then grant
        wr(2'd3, 16'd0);
        wr(2'd2, mword(0, 0, 1'b1, 1'b0));
        wr(2'd1, 16'd2);
        dreq = 1'b1;
        tick();
        chk(dack === 1'b1, "R8 unmask restores grant", 32'(dack), 1);
        dreq = 1'b0;
        tick(); tick(); tick();
        chk(dack === 1'b0, "R5 verify service ends", 32'(dack), 0);

        // demand mode pause / resume, tc with dreq loss in same cycle
        wr(2'd2, mword(1, 1, 1'b0, 1'b0));
        wr(2'd0, 16'h0100); wr(2'd1, 16'd5);
        dreq = 1'b1;
        tick();
        chk(addr_o === 16'h0100, "R6 first transfer", 32'(addr_o), 32'h0100);
        tick();
        chk(addr_o === 16'h0101, "R6 second transfer", 32'(addr_o), 32'h0101);
        dreq = 1'b0;
        tick();
        chk(dack === 1'b0, "R6 paused", 32'(dack), 0);
        chk(cnt_o === 16'd3, "R6 count kept", 32'(cnt_o), 3);
        tick(); tick();
        chk(cnt_o === 16'd3, "R6 count held idle", 32'(cnt_o), 3);
        dreq = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(addr_o === 16'h0102 + 16'(i), "R6 resumed address", 32'(addr_o), 32'h0102 + i);
            chk(tc === (i == 3), "R4 tc demand", 32'(tc), 32'(i == 3));
            if (i == 3) dreq = 1'b0;
            tick();
        end
        chk(dack === 1'b0, "R4 tc with dreq loss", 32'(dack), 0);
        chk(cnt_o === 16'hFFFF, "R8 demand wrap", 32'(cnt_o), 32'hFFFF);
        dreq = 1'b1;
        tick(); tick();
        chk(dack === 1'b0, "R8 masked after demand tc", 32'(dack), 0);
        dreq = 1'b0;
        wr(2'd3, 16'd0);

        // cascade
        wr(2'd2, mword(2, 1, 1'b0, 1'b0));
        wr(2'd0, 16'h4000); wr(2'd1, 16'd7);
        dreq = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(dack === 1'b1 && bus_en === 1'b0, "R9 cascade grant", 32'({dack, bus_en}), 2);
            chk({io_rd, io_wr, mem_rd, mem_wr, tc} === 5'b0 && addr_o === 16'd0, "R9 bus quiet",
                32'({io_rd, io_wr, mem_rd, mem_wr, tc, addr_o}), 0);
            chk(cnt_o === 16'd7, "R9 count unchanged", 32'(cnt_o), 7);
            if (i == 1) wr(2'd1, 16'd9); else tick();
        end
        chk(cnt_o === 16'd7, "R2 write ignored while busy", 32'(cnt_o), 7);
        dreq = 1'b0;
        tick();
        chk(dack === 1'b0, "R9 release", 32'(dack), 0);
        chk(cnt_o === 16'd7, "R2 current kept", 32'(cnt_o), 7);
        wr(2'd1, 16'd9);
        chk(cnt_o === 16'd9, "R2 idle write loads", 32'(cnt_o), 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule